// File: doc/BRIEF.md
# Conditional ALU with flags

This block is the data-processing execute stage of a 32-bit RISC pipeline. Each cycle it may take one decoded operation: the condition, opcode, flag-set bit and destination index from the instruction word, the first source operand, the second operand and carry-out already produced by the shifter, and the current N, Z, C and V status flags. One clock later it presents the ALU result, the destination index, a destination write enable, the next flag values with a flag write enable, and two strobes. One strobe asks for a saved status word to be restored. The other reports an undefined condition code.

The condition code is checked against the incoming flags before anything takes effect. When the check fails, no write enable is raised and the flags pass through unchanged. All sixteen data-processing operations are supported. Subtraction defines carry as "no borrow". The four compare and test operations update only the flags. The register file, the shifter and the status-restore logic belong to neighbouring blocks.

Top module: `alu_exec_stage`

## Requirements
- R1: After synchronous reset, and in every cycle where out_valid is low, out_valid, rd_we, flags_we, restore_req and undef_instr are all 0.
- R2: Each operation accepted with in_valid high produces its outputs with out_valid high exactly one clock later. rd_idx carries the destination index rd_in of that operation.
- R3: cond_in selects the test, with the flags packed into flags_in as {N,Z,C,V} (bit 3 = N, bit 0 = V). The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. When the test fails, rd_we, flags_we and restore_req are 0 and flags_out equals flags_in.
- R4: cond_in = 15 raises undef_instr. No write enable and no restore request is raised, and flags_out equals flags_in.
- R5: opc_in selects the operation: 0 AND, 1 EOR, 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV (b), 14 BIC (a AND NOT b), 15 MVN (NOT b). Here a is rn_val and b is shop_val.
- R6: Add forms (ADD, ADC, CMN) set C to the unsigned carry out of bit 31 and V to bit 31 of ~(x^y)&(res^x).
- R7: Subtract forms (SUB, RSB, CMP, SBC, RSC) set C when no borrow occurs and V to bit 31 of (x^y)&(res^x), with x the minuend and y the subtrahend.
- R8: ADC adds C, while SBC and RSC subtract NOT C. Their C and V come from the full-width result including that carry term.
- R9: Logical operations with flag update set N to result bit 31, Z when the result is zero, and C to shop_carry. V is left unchanged.
- R10: TST, TEQ, CMP and CMN that pass their condition always raise flags_w e and never raise rd_we, whatever the flag-set bit or destination is.
- R11: A non-compare operation that passes with set_flags = 0 raises rd_we and leaves flags_we low, with flags_out equal to flags_in.
- R12: A non-compare operation that passes with set_flags = 1 and rd_in = 15 raises rd_we and restore_req and leaves flags_we low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| cond_in | input | 4 | Condition field of the instruction |
| opc_in | input | 4 | Data-processing opcode field |
| set_flags | input | 1 | Flag-update bit of the instruction |
| rd_in | input | 4 | Destination register index |
| rn_val | input | 32 | First operand value |
| shop_val | input | 32 | Second operand from the shifter |
| shop_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Outputs below belong to an accepted operation |
| result | output | 32 | ALU result |
| rd_idx | output | 4 | Destination index for the write |
| rd_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_we | output | 1 | Flag write enable |
| restore_req | output | 1 | Request to restore the saved status word |
| undef_instr | output | 1 | Condition code 15 seen |

## Verification
The properties assume the inputs are stable and fully defined in any cycle where in_valid is high. They also assume flags_in in the cycle of issue is the flag state the operation must see. In other words, the block is not expected to forward its own flag output. The stimulus presents each operation for one cycle with explicit flag values, and those values are chosen independently of any earlier result. Directed sequences cover every condition code under all sixteen flag patterns and the carry and overflow boundaries. A long run then draws random fields and mostly keeps the destination index away from 15, so that the restore path stays an occasional case.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [3:0] {
    OPC_AND = 4'd0,  OPC_EOR = 4'd1,  OPC_SUB = 4'd2,  OPC_RSB = 4'd3,
    OPC_ADD = 4'd4,  OPC_ADC = 4'd5,  OPC_SBC = 4'd6,  OPC_RSC = 4'd7,
    OPC_TST = 4'd8,  OPC_TEQ = 4'd9,  OPC_CMP = 4'd10, OPC_CMN = 4'd11,
    OPC_ORR = 4'd12, OPC_MOV = 4'd13, OPC_BIC = 4'd14, OPC_MVN = 4'd15
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam logic [3:0] COND_UNDEF = 4'hF;

  // compare/test group occupies opcodes 8..11
  function automatic logic opc_is_compare(input opc_e o);
    return o[3:2] == 2'b10;
  endfunction

endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_exec_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      flg,
  output logic       pass,
  output logic       undef
);
  logic base;

  // codes come in complementary pairs: even = test, odd = inverted test
  always_comb begin
    case (cond[3:1])
      3'd0:    base = flg.z;
      3'd1:    base = flg.c;
      3'd2:    base = flg.n;
      3'd3:    base = flg.v;
      3'd4:    base = flg.c & ~flg.z;
      3'd5:    base = (flg.n == flg.v);
      3'd6:    base = ~flg.z & (flg.n == flg.v);
      default: base = 1'b1;
    endcase
    undef = (cond == COND_UNDEF);
    pass  = base ^ cond[0];
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  opc_e         opc,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         arith,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y, lres;
  logic         ci;
  logic [W:0]   sum;

  // single adder; subtraction is x + ~y + carry-in
  always_comb begin
    x     = '0;
    y     = '0;
    ci    = 1'b0;
    arith = 1'b1;
    lres  = '0;
    case (opc)
      OPC_SUB, OPC_CMP: begin x = a; y = ~b; ci = 1'b1; end
      OPC_RSB:          begin x = b; y = ~a; ci = 1'b1; end
      OPC_ADD, OPC_CMN: begin x = a; y = b;  ci = 1'b0; end
      OPC_ADC:          begin x = a; y = b;  ci = cin;  end
      OPC_SBC:          begin x = a; y = ~b; ci = cin;  end
      OPC_RSC:          begin x = b; y = ~a; ci = cin;  end
      OPC_AND, OPC_TST: begin arith = 1'b0; lres = a & b;  end
      OPC_EOR, OPC_TEQ: begin arith = 1'b0; lres = a ^ b;  end
      OPC_ORR:          begin arith = 1'b0; lres = a | b;  end
      OPC_MOV:          begin arith = 1'b0; lres = b;      end
      OPC_BIC:          begin arith = 1'b0; lres = a & ~b; end
      default:          begin arith = 1'b0; lres = ~b;     end
    endcase
  end

  assign sum  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign res  = arith ? sum[MSB:0] : lres;
  assign cout = sum[W];
  assign ovf  = (x[MSB] == y[MSB]) & (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         pass,
  input  opc_e         opc,
  input  logic         set_flags,
  input  logic         rd_is_pc,
  input  logic [W-1:0] res,
  input  logic         arith,
  input  logic         cout,
  input  logic         ovf,
  input  logic         shc,
  input  nzcv_t        fin,
  output nzcv_t        fout,
  output logic         fwe,
  output logic         rwe,
  output logic         rreq
);
  nzcv_t calc;
  logic  cmp;

  assign cmp = opc_is_compare(opc);

  always_comb begin
    calc.n = res[W-1];
    calc.z = (res == '0);
    calc.c = arith ? cout : shc;
    calc.v = arith ? ovf  : fin.v;
  end

  always_comb begin
    fwe  = 1'b0;
    rwe  = 1'b0;
    rreq = 1'b0;
    if (pass) begin
      if (cmp) begin
        fwe = 1'b1;
      end else begin
        rwe = 1'b1;
        if (set_flags) begin
          if (rd_is_pc) rreq = 1'b1;
          else          fwe  = 1'b1;
        end
      end
    end
    fout = fwe ? calc : fin;
  end
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        cond_in,
  input  logic [3:0]        opc_in,
  input  logic              set_flags,
  input  logic [IDX_W-1:0]  rd_in,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] shop_val,
  input  logic              shop_carry,
  input  logic [3:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_we,
  output logic [3:0]        flags_out,
  output logic              flags_we,
  output logic              restore_req,
  output logic              undef_instr
);
  localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

  opc_e              opc;
  nzcv_t             fin, fnext;
  logic              pass, undef;
  logic [DATA_W-1:0] res;
  logic              arith, cout, ovf;
  logic              fwe, rwe, rreq;

  assign opc = opc_e'(opc_in);
  assign fin = nzcv_t'(flags_in);

  alu_cond_eval u_cond (
    .cond (cond_in),
    .flg  (fin),
    .pass (pass),
    .undef(undef)
  );

  alu_datapath #(.W(DATA_W)) u_dp (
    .opc  (opc),
    .a    (rn_val),
    .b    (shop_val),
    .cin  (fin.c),
    .res  (res),
    .arith(arith),
    .cout (cout),
    .ovf  (ovf)
  );

  alu_flag_unit #(.W(DATA_W)) u_flg (
    .pass     (pass & ~undef),
    .opc      (opc),
    .set_flags(set_flags),
    .rd_is_pc (rd_in == PC_IDX),
    .res      (res),
    .arith    (arith),
    .cout     (cout),
    .ovf      (ovf),
    .shc      (shop_carry),
    .fin      (fin),
    .fout     (fnext),
    .fwe      (fwe),
    .rwe      (rwe),
    .rreq     (rreq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      result      <= '0;
      rd_idx      <= '0;
      rd_we       <= 1'b0;
      flags_out   <= '0;
      flags_we    <= 1'b0;
      restore_req <= 1'b0;
      undef_instr <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      rd_we       <= in_valid & rwe;
      flags_we    <= in_valid & fwe;
      restore_req <= in_valid & rreq;
      undef_instr <= in_valid & undef;
      if (in_valid) begin
        result    <= res;
        rd_idx    <= rd_in;
        flags_out <= fnext;
      end
    end
  end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] opc_grp,
  input logic [3:0] flags_in,
  input logic       out_valid,
  input logic       rd_we,
  input logic [3:0] flags_out,
  input logic       flags_we,
  input logic       restore_req,
  input logic       undef_instr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!rd_we && !flags_we && !restore_req && !undef_instr));

  // R2
  issue_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R4
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    undef_instr |-> (!rd_we && !flags_we && !restore_req));

  // R12
  restore_excl_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> (rd_we && !flags_we));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !flags_we) |-> (flags_out == $past(flags_in)));

  // R10
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opc_grp == 2'b10) |=> !rd_we);
endmodule

bind alu_exec_stage alu_exec_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .opc_grp    (opc_in[3:2]),
  .flags_in   (flags_in),
  .out_valid  (out_valid),
  .rd_we      (rd_we),
  .flags_out  (flags_out),
  .flags_we   (flags_we),
  .restore_req(restore_req),
  .undef_instr(undef_instr)
);

// File: tb/sim_alu_exec_stage.sv
module sim_alu_exec_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  cond_in = '0, opc_in = '0, rd_in = '0, flags_in = '0;
  logic        set_flags = 1'b0, shop_carry = 1'b0;
  logic [31:0] rn_val = '0, shop_val = '0;
  logic        out_valid, rd_we, flags_we, restore_req, undef_instr;
  logic [31:0] result;
  logic [3:0]  rd_idx, flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  rd;
    logic        rwe, fwe, rreq, und;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  alu_exec_stage u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_in(cond_in),
    .opc_in(opc_in), .set_flags(set_flags), .rd_in(rd_in),
    .rn_val(rn_val), .shop_val(shop_val), .shop_carry(shop_carry),
    .flags_in(flags_in), .out_valid(out_valid), .result(result),
    .rd_idx(rd_idx), .rd_we(rd_we), .flags_out(flags_out),
    .flags_we(flags_we), .restore_req(restore_req), .undef_instr(undef_instr)
  );

  function automatic exp_t model(input logic [3:0] c, input logic [3:0] o,
      input logic s, input logic [3:0] rd, input logic [31:0] a,
      input logic [31:0] b, input logic sc, input logic [3:0] f, input string tag);
    exp_t e;
    logic n = f[3], z = f[2], cf = f[1], v = f[0];
    logic ok, ar, cc, vv;
    logic [31:0] r, x, y;
    logic [63:0] t;
    longint d;
    bit sub, addc;
    case (c)
      4'd0: ok = z;        4'd1: ok = !z;
      4'd2: ok = cf;       4'd3: ok = !cf;
      4'd4: ok = n;        4'd5: ok = !n;
      4'd6: ok = v;        4'd7: ok = !v;
      4'd8: ok = cf && !z; 4'd9: ok = !cf || z;
      4'd10: ok = (n == v); 4'd11: ok = (n != v);
      4'd12: ok = !z && (n == v); 4'd13: ok = z || (n != v);
      4'd14: ok = 1'b1;    default: ok = 1'b0;
    endcase
    ar = 1'b1; sub = 1'b0; x = a; y = b; addc = 1'b0; r = '0;
    case (o)
      4'd2, 4'd10: begin sub = 1; addc = 1; end
      4'd3:        begin sub = 1; addc = 1; x = b; y = a; end
      4'd4, 4'd11: begin addc = 0; end
      4'd5:        begin addc = cf; end
      4'd6:        begin sub = 1; addc = cf; end
      4'd7:        begin sub = 1; addc = cf; x = b; y = a; end
      4'd0, 4'd8:  begin ar = 0; r = a & b; end
      4'd1, 4'd9:  begin ar = 0; r = a ^ b; end
      4'd12:       begin ar = 0; r = a | b; end
      4'd13:       begin ar = 0; r = b; end
      4'd14:       begin ar = 0; r = a & ~b; end
      default:     begin ar = 0; r = ~b; end
    endcase
    cc = sc; vv = v;
    if (ar && sub) begin
      d  = longint'(x) - longint'(y) - (addc ? 0 : 1);
      r  = d[31:0];
      cc = (d >= 0);
      vv = ((x ^ y) & (r ^ x)) >> 31;
    end else if (ar) begin
      t  = 64'(x) + 64'(y) + 64'(addc);
      r  = t[31:0];
      cc = t[32];
      vv = (~(x ^ y) & (r ^ x)) >> 31;
    end
    e.res = r; e.rd = rd; e.tag = tag;
    e.und = (c == 4'hF);
    e.rwe = 0; e.fwe = 0; e.rreq = 0;
    if (ok) begin
      if (o >= 4'd8 && o <= 4'd11) e.fwe = 1;
      else begin
        e.rwe = 1;
        if (s) begin
          if (rd == 4'hF) e.rreq = 1;
          else e.fwe = 1;
        end
      end
    end
    e.fl = e.fwe ? {r[31], (r == 0), cc, vv} : f;
    return e;
  endfunction

  task automatic send(input logic [3:0] c, input logic [3:0] o, input logic s,
      input logic [3:0] rd, input logic [31:0] a, input logic [31:0] b,
      input logic sc, input logic [3:0] f, input string tag);
    @(negedge clk);
    in_valid = 1'b1; cond_in = c; opc_in = o; set_flags = s; rd_in = rd;
    rn_val = a; shop_val = b; shop_carry = sc; flags_in = f;
    sb.push_back(model(c, o, s, rd, a, b, sc, f, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: out_valid with no pending item act=1 exp=0");
      end else begin
        e = sb.pop_front();
        if (rd_we !== e.rwe || flags_we !== e.fwe || restore_req !== e.rreq ||
            undef_instr !== e.und || flags_out !== e.fl || rd_idx !== e.rd ||
            (e.rwe && result !== e.res)) begin
          fails++;
          $display("FAIL %s: act res=%h rd=%0d we=%b fwe=%b rr=%b ud=%b fl=%b exp res=%h rd=%0d we=%b fwe=%b rr=%b ud=%b fl=%b",
            e.tag, result, rd_idx, rd_we, flags_we, restore_req, undef_instr, flags_out,
            e.res, e.rd, e.rwe, e.fwe, e.rreq, e.und, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 0 || rd_we !== 0 || flags_we !== 0 || restore_req !== 0 || undef_instr !== 0) begin
      fails++;
      $display("FAIL R1: act v=%b we=%b fwe=%b rr=%b ud=%b exp all 0", out_valid, rd_we, flags_we, restore_req, undef_instr);
    end
    rst = 1'b0;
    idle();
    // R3 every condition under every flag pattern
    for (int c = 0; c < 15; c++)
      for (int f = 0; f < 16; f++)
        send(4'(c), 4'd13, 1'b0, 4'd3, 32'h0, 32'h1234_0000 + 32'(c * 16 + f), 1'b0, 4'(f), "R3");
    // R4 undefined condition
    send(4'hF, 4'd4, 1'b1, 4'd2, 32'd1, 32'd2, 1'b0, 4'b0000, "R4");
    send(4'hF, 4'd10, 1'b1, 4'd2, 32'd1, 32'd2, 1'b0, 4'b1010, "R4");
    // R5 each opcode, plain form
    for (int o = 0; o < 16; o++)
      send(4'd14, 4'(o), 1'b0, 4'd5, 32'hF0F0_1234, 32'h0FF0_0011, 1'b1, 4'b0010, "R5");
    // R6 add forms
    send(4'd14, 4'd4, 1'b1, 4'd1, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, "R6");
    send(4'd14, 4'd4, 1'b1, 4'd1, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, "R6");
    send(4'd14, 4'd11, 1'b0, 4'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000, "R6");
    // R7 subtract forms
    send(4'd14, 4'd2, 1'b1, 4'd1, 32'd5, 32'd5, 1'b0, 4'b0000, "R7");
    send(4'd14, 4'd2, 1'b1, 4'd1, 32'd3, 32'd5, 1'b0, 4'b0000, "R7");
    send(4'd14, 4'd2, 1'b1, 4'd1, 32'h8000_0000, 32'd1, 1'b0, 4'b0000, "R7");
    send(4'd14, 4'd3, 1'b1, 4'd1, 32'd7, 32'd2, 1'b0, 4'b0000, "R7");
    send(4'd14, 4'd10, 1'b1, 4'd1, 32'd2, 32'd9, 1'b0, 4'b0001, "R7");
    // R8 carry-using forms
    send(4'd14, 4'd5, 1'b1, 4'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, 4'b0010, "R8");
    send(4'd14, 4'd6, 1'b1, 4'd1, 32'd5, 32'd5, 1'b0, 4'b0000, "R8");
    send(4'd14, 4'd6, 1'b1, 4'd1, 32'd5, 32'd5, 1'b0, 4'b0010, "R8");
    send(4'd14, 4'd7, 1'b1, 4'd1, 32'd4, 32'd4, 1'b0, 4'b0000, "R8");
    send(4'd14, 4'd7, 1'b1, 4'd1, 32'h0, 32'h8000_0000, 1'b0, 4'b0010, "R8");
    // R9 logical flag forms
    send(4'd14, 4'd0, 1'b1, 4'd1, 32'hF000_0000, 32'h8000_0001, 1'b1, 4'b0001, "R9");
    send(4'd14, 4'd13, 1'b1, 4'd1, 32'h0, 32'h0, 1'b0, 4'b1011, "R9");
    send(4'd14, 4'd15, 1'b1, 4'd1, 32'h0, 32'h0, 1'b1, 4'b0100, "R9");
    send(4'd14, 4'd14, 1'b1, 4'd1, 32'hFF, 32'hFF, 1'b1, 4'b0000, "R9");
    send(4'd14, 4'd12, 1'b1, 4'd1, 32'h1, 32'h2, 1'b0, 4'b0011, "R9");
    send(4'd14, 4'd1, 1'b1, 4'd1, 32'hA5, 32'hA5, 1'b1, 4'b1001, "R9");
    // R10 compares: no write, flags even with S=0 or rd=15
    send(4'd14, 4'd8, 1'b0, 4'd6, 32'hF0, 32'h0F, 1'b1, 4'b0000, "R10");
    send(4'd14, 4'd9, 1'b1, 4'd15, 32'h1, 32'h1, 1'b0, 4'b1110, "R10");
    send(4'd14, 4'd10, 1'b1, 4'd15, 32'd9, 32'd9, 1'b0, 4'b0000, "R10");
    // R11 no flag update without S
    send(4'd14, 4'd4, 1'b0, 4'd7, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b1001, "R11");
    send(4'd14, 4'd2, 1'b0, 4'd15, 32'd1, 32'd1, 1'b0, 4'b0110, "R11");
    // R12 restore request on pc destination
    send(4'd14, 4'd2, 1'b1, 4'd15, 32'd4, 32'd4, 1'b0, 4'b1000, "R12");
    send(4'd14, 4'd13, 1'b1, 4'd15, 32'd0, 32'h40, 1'b1, 4'b0000, "R12");
    send(4'd0, 4'd13, 1'b1, 4'd15, 32'd0, 32'h40, 1'b1, 4'b0000, "R12");
    // R2 gap then back-to-back resumes
    idle();
    idle();
    checks++;
    if (out_valid !== 1'b0 || rd_we !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle act v=%b we=%b exp 0 0", out_valid, rd_we);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rd = ($urandom_range(0, 7) == 0) ? 4'hF : 4'($urandom_range(0, 14));
      send(4'($urandom), 4'($urandom), 1'($urandom), rd, $urandom, $urandom,
           1'($urandom), 4'($urandom), "R5");
    end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: pending act=%0d exp=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule